// File: doc/BRIEF.md
# Tick-Driven Real-Time Clock with Timer Interrupt Flags

This block keeps wall-clock time by counting an external enable pulse that arrives every 5 ms. The pulse drives a chain of five counters with uneven moduli: a base counter, seconds, minutes, and two higher stages. The base counter produces two kinds of events. A tick fires every tenth pulse, and a seconds event fires when the base counter wraps. A minutes event fires when the seconds counter wraps. All three events land in a 3-bit timer status register.

Software reaches the block through an 8-bit port bus. It can read the five counters, read the status (which clears it), acknowledge single status bits, and load a 3-bit mask. A control port carries a bit that clears the counters and holds them at zero. The pending output goes to the system interrupt controller. It is high while the timer interrupt enable from that controller is on and an unmasked status bit is set.

Top module: `rtc_tick_timer`

## Requirements
- R1: Each cycle with `strobe_i` high and the hold bit clear advances the base counter by one. It wraps from BASE_MOD-1 (default 199) to 0. Its value reads at port 0xD0.
- R2: Status bit 0 (tick) is set whenever the base counter advances to a multiple of TICK_DIV (default 10), including its wrap to 0.
- R3: A base wrap sets status bit 1 (seconds) and advances the seconds counter, read at 0xD1, which wraps at SEC_MOD (default 60). That wrap sets status bit 2 (minutes) and advances the minutes counter, read at 0xD2.
- R4: The minutes counter wraps at MIN_MOD (default 256) and advances the next counter (0xD3, modulo MID_MOD, default 256). That counter's wrap advances the top counter (0xD4, modulo TOP_MOD, default 32).
- R5: Writing port 0xB0 with bit 4 set zeroes all counters. While the stored bit 4 is 1, strobes do not change any counter. Writing bit 4 as 0 resumes counting.
- R6: Writing port 0xB4 clears the status bits that are 1 in data bits [2:0]. If an event sets a bit in the same cycle as its acknowledge, the bit ends set.
- R7: Writing port 0xB5 loads data bits [2:0] into the mask. Reading port 0xB5 returns {5'b0, status} and clears the status at the end of the read cycle.
- R8: `pend_o` is `irq_en_i` AND (any bit set in status AND mask). It follows status, mask and enable changes with no added cycle.
- R9: A read from 0xD1 returns only bits [5:0] and a read from 0xD4 only bits [4:0]. Any port other than 0xB5 and 0xD0..0xD4 reads as 0xFF. Counter reads have no side effect.
- R10: After reset, all counters, the status, the mask and the hold bit are 0, and `pend_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | One-cycle 5 ms advance pulse |
| irq_en_i | input | 1 | Timer interrupt enable from the interrupt controller |
| io_addr_i | input | 8 | Port address (low byte) |
| io_wdata_i | input | 8 | Write data |
| io_wr_i | input | 1 | Write strobe |
| io_rd_i | input | 1 | Read strobe |
| io_rdata_o | output | 8 | Read data, combinational on the address |
| pend_o | output | 1 | Timer interrupt pending |

## Verification
The bench drives an acknowledge in the same cycle as the strobe that makes a tick. A design that lets the acknowledge win would lose that tick and read back zero status. It runs the whole counter chain through every carry up to a full rollover, using shortened moduli. A wrong carry source or a wrong modulus shows up as a wrong count in an upper stage. It also checks that masking and the enable both gate `pend_o`, that a second status read returns zero, and that a held clock stays at zero under strobes. A design that clears only on the write, and not throughout the hold, would creep forward.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned NSTG     = 5;
  localparam int unsigned HOLD_BIT = 4;
  localparam int unsigned EV_TICK  = 0;
  localparam int unsigned EV_SEC   = 1;
  localparam int unsigned EV_MIN   = 2;

  localparam logic [7:0] ADDR_CTRL = 8'hB0;
  localparam logic [7:0] ADDR_ACK  = 8'hB4;
  localparam logic [7:0] ADDR_TMR  = 8'hB5;
  localparam logic [7:0] ADDR_CNT  = 8'hD0;

  // per-stage read masks, index 0 = base counter
  localparam logic [NSTG-1:0][7:0] CNT_RD_MASK = {8'h1F, 8'hFF, 8'hFF, 8'h3F, 8'hFF};
endpackage

// File: rtl/rtc_stage.sv
module rtc_stage #(
  parameter int unsigned MOD = 10,
  parameter int unsigned W   = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] LAST = W'(MOD - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (inc_i) cnt_o <= (cnt_o == LAST) ? '0 : cnt_o + 1'b1;
  end
endmodule

// File: rtl/rtc_chain.sv
module rtc_chain
  import rtc_pkg::*;
#(
  parameter int unsigned BASE_MOD = 200,
  parameter int unsigned TICK_DIV = 10,
  parameter int unsigned SEC_MOD  = 60,
  parameter int unsigned MIN_MOD  = 256,
  parameter int unsigned MID_MOD  = 256,
  parameter int unsigned TOP_MOD  = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 adv_i,
  output logic [NSTG-1:0][7:0] cnt_o,
  output logic [2:0]           ev_o
);
  localparam int unsigned MOD_TAB [NSTG] = '{BASE_MOD, SEC_MOD, MIN_MOD, MID_MOD, TOP_MOD};
  localparam logic [7:0]  DIV_LAST = 8'(TICK_DIV - 1);

  logic [NSTG-1:0] inc_w;
  logic [NSTG-2:0] carry_w;
  logic [7:0]      div_cnt;
  logic            div_carry;

  assign inc_w[0] = adv_i & ~clr_i;

  for (genvar i = 0; i < NSTG; i++) begin : g_stg
    if (i > 0) begin : g_link
      assign inc_w[i] = carry_w[i-1];
    end
    if (i < NSTG - 1) begin : g_carry
      assign carry_w[i] = inc_w[i] && (cnt_o[i] == 8'(MOD_TAB[i] - 1));
    end
    rtc_stage #(.MOD(MOD_TAB[i]), .W(8)) u_stage (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (clr_i),
      .inc_i (inc_w[i]),
      .cnt_o (cnt_o[i])
    );
  end

  // tick divider runs in lockstep with the base counter (BASE_MOD % TICK_DIV == 0)
  rtc_stage #(.MOD(TICK_DIV), .W(8)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr_i),
    .inc_i (inc_w[0]),
    .cnt_o (div_cnt)
  );
  assign div_carry = inc_w[0] && (div_cnt == DIV_LAST);

  always_comb begin
    ev_o          = '0;
    ev_o[EV_TICK] = div_carry;
    ev_o[EV_SEC]  = carry_w[0];
    ev_o[EV_MIN]  = carry_w[1];
  end
endmodule

// File: rtl/rtc_evt.sv
module rtc_evt (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] ev_i,
  input  logic       ack_we_i,
  input  logic       msk_we_i,
  input  logic       stat_rd_i,
  input  logic [2:0] wdata_i,
  input  logic       irq_en_i,
  output logic [2:0] stat_o,
  output logic [2:0] msk_o,
  output logic       pend_o
);
  logic [2:0] clr_m;

  assign clr_m = (ack_we_i ? wdata_i : 3'b000) | (stat_rd_i ? 3'b111 : 3'b000);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_o <= '0;
      msk_o  <= '0;
    end else begin
      stat_o <= (stat_o & ~clr_m) | ev_i;  // event beats clear
      if (msk_we_i) msk_o <= wdata_i;
    end
  end

  assign pend_o = irq_en_i & |(stat_o & msk_o);
endmodule

// File: rtl/rtc_tick_timer.sv
module rtc_tick_timer
  import rtc_pkg::*;
#(
  parameter int unsigned BASE_MOD = 200,
  parameter int unsigned TICK_DIV = 10,
  parameter int unsigned SEC_MOD  = 60,
  parameter int unsigned MIN_MOD  = 256,
  parameter int unsigned MID_MOD  = 256,
  parameter int unsigned TOP_MOD  = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       strobe_i,
  input  logic       irq_en_i,
  input  logic [7:0] io_addr_i,
  input  logic [7:0] io_wdata_i,
  input  logic       io_wr_i,
  input  logic       io_rd_i,
  output logic [7:0] io_rdata_o,
  output logic       pend_o
);
  logic                 hold_q;
  logic                 ctrl_we, clr_cnt, adv;
  logic [NSTG-1:0][7:0] cnt_w;
  logic [2:0]           ev_w, stat_q, msk_q;
  logic                 unused_wdata;

  assign ctrl_we      = io_wr_i && (io_addr_i == ADDR_CTRL);
  assign clr_cnt      = ctrl_we && io_wdata_i[HOLD_BIT];
  assign adv          = strobe_i && !hold_q;
  assign unused_wdata = ^{io_wdata_i[7:5], io_wdata_i[3]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hold_q <= 1'b0;
    else if (ctrl_we) hold_q <= io_wdata_i[HOLD_BIT];
  end

  rtc_chain #(
    .BASE_MOD(BASE_MOD), .TICK_DIV(TICK_DIV), .SEC_MOD(SEC_MOD),
    .MIN_MOD(MIN_MOD), .MID_MOD(MID_MOD), .TOP_MOD(TOP_MOD)
  ) u_chain (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr_cnt),
    .adv_i (adv),
    .cnt_o (cnt_w),
    .ev_o  (ev_w)
  );

  rtc_evt u_evt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ev_i     (ev_w),
    .ack_we_i (io_wr_i && (io_addr_i == ADDR_ACK)),
    .msk_we_i (io_wr_i && (io_addr_i == ADDR_TMR)),
    .stat_rd_i(io_rd_i && (io_addr_i == ADDR_TMR)),
    .wdata_i  (io_wdata_i[2:0]),
    .irq_en_i (irq_en_i),
    .stat_o   (stat_q),
    .msk_o    (msk_q),
    .pend_o   (pend_o)
  );

  always_comb begin
    io_rdata_o = 8'hFF;
    if (io_addr_i == ADDR_TMR) io_rdata_o = {5'b0, stat_q};
    for (int i = 0; i < NSTG; i++) begin
      if (io_addr_i == ADDR_CNT + 8'(i)) io_rdata_o = cnt_w[i] & CNT_RD_MASK[i];
    end
  end
endmodule

// File: rtl/rtc_tick_timer_chk.sv
module rtc_tick_timer_chk
  import rtc_pkg::*;
#(
  parameter int unsigned BASE_MOD = 200
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       strobe_i,
  input logic       irq_en_i,
  input logic [7:0] io_addr_i,
  input logic [7:0] io_wdata_i,
  input logic       io_wr_i,
  input logic       io_rd_i,
  input logic       pend_o,
  input logic       hold_q,
  input logic [2:0] stat_q,
  input logic [7:0] base_q
);
  // R1
  base_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i && !hold_q && base_q == 8'(BASE_MOD - 1) |=> base_q == 8'd0);

  // R1
  idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i && !(io_wr_i && io_addr_i == ADDR_CTRL) |=> $stable(base_q));

  // R5
  hold_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_q && !(io_wr_i && io_addr_i == ADDR_CTRL) |=> $stable(base_q));

  // R6
  ack_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_wr_i && io_addr_i == ADDR_ACK && !strobe_i |=> (stat_q & $past(io_wdata_i[2:0])) == 3'b000);

  // R7
  rd_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_rd_i && io_addr_i == ADDR_TMR && !strobe_i |=> stat_q == 3'b000);

  // R8
  pend_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i |-> !pend_o);
endmodule

bind rtc_tick_timer rtc_tick_timer_chk #(.BASE_MOD(BASE_MOD)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .strobe_i  (strobe_i),
  .irq_en_i  (irq_en_i),
  .io_addr_i (io_addr_i),
  .io_wdata_i(io_wdata_i),
  .io_wr_i   (io_wr_i),
  .io_rd_i   (io_rd_i),
  .pend_o    (pend_o),
  .hold_q    (hold_q),
  .stat_q    (stat_q),
  .base_q    (cnt_w[0])
);

// File: tb/rtc_tick_timer_tb.sv
module rtc_tick_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 5;
  // {strobes, base, sec, min, status}; moduli 20/10/4/4/4/4
  localparam logic [39:0] VEC [NVEC] = '{
    {8'd3,  8'd3,  8'd0, 8'd0, 8'h00},
    {8'd7,  8'd10, 8'd0, 8'd0, 8'h01},
    {8'd10, 8'd0,  8'd1, 8'd0, 8'h03},
    {8'd60, 8'd0,  8'd0, 8'd1, 8'h07},
    {8'd5,  8'd5,  8'd0, 8'd1, 8'h00}
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic strobe = 1'b0, irq_en = 1'b0, io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0] io_addr = 8'h00, io_wdata = 8'h00, rdata;
  logic pend;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_tick_timer #(
    .BASE_MOD(20), .TICK_DIV(10), .SEC_MOD(4),
    .MIN_MOD(4), .MID_MOD(4), .TOP_MOD(4)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .strobe_i(strobe), .irq_en_i(irq_en),
    .io_addr_i(io_addr), .io_wdata_i(io_wdata), .io_wr_i(io_wr), .io_rd_i(io_rd),
    .io_rdata_o(rdata), .pend_o(pend)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); io_wr = 1'b1; io_addr = a; io_wdata = d;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); io_rd = 1'b1; io_addr = a;
    #1 d = rdata;
    @(negedge clk); io_rd = 1'b0;
  endtask

  task automatic pulse(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); strobe = 1'b1;
    end
    @(negedge clk); strobe = 1'b0;
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R10 reset state
    for (int i = 0; i < 5; i++) begin
      rd(8'hD0 + 8'(i), v); check("R10 counter", v, 8'h00);
    end
    rd(8'hB5, v); check("R10 status", v, 8'h00);
    irq_en = 1'b1; #1 check("R10 pend", {7'b0, pend}, 8'h00); irq_en = 1'b0;

    // R1 R2 R3 vector table
    for (int i = 0; i < NVEC; i++) begin
      pulse(int'(VEC[i][39:32]));
      rd(8'hD0, v); check("R1 base", v, VEC[i][31:24]);
      rd(8'hD1, v); check("R3 seconds", v, VEC[i][23:16]);
      rd(8'hD2, v); check("R3 minutes", v, VEC[i][15:8]);
      rd(8'hB5, v); check("R2 status", v, VEC[i][7:0]);
    end

    // R6 event in same cycle as its acknowledge
    pulse(4);
    rd(8'hB5, v); check("R6 pre", v, 8'h00);
    @(negedge clk); strobe = 1'b1; io_wr = 1'b1; io_addr = 8'hB4; io_wdata = 8'h01;
    @(negedge clk); strobe = 1'b0; io_wr = 1'b0;
    rd(8'hB5, v); check("R6 event wins", v, 8'h01);

    // R8 mask and enable gating
    wr(8'hB5, 8'h02); irq_en = 1'b1;
    #1 check("R8 idle", {7'b0, pend}, 8'h00);
    pulse(10);
    #1 check("R8 seconds pend", {7'b0, pend}, 8'h01);
    wr(8'hB4, 8'h02);
    #1 check("R6 ack seconds", {7'b0, pend}, 8'h00);
    wr(8'hB5, 8'h01);
    #1 check("R7 mask tick", {7'b0, pend}, 8'h01);
    irq_en = 1'b0;
    #1 check("R8 enable off", {7'b0, pend}, 8'h00);
    irq_en = 1'b1;
    rd(8'hB5, v); check("R7 read status", v, 8'h01);
    #1 check("R8 after clear", {7'b0, pend}, 8'h00);
    rd(8'hB5, v); check("R7 second read", v, 8'h00);

    // R5 hold
    wr(8'hB0, 8'h10);
    rd(8'hD2, v); check("R5 clear min", v, 8'h00);
    pulse(5);
    rd(8'hD0, v); check("R5 frozen", v, 8'h00);
    wr(8'hB0, 8'h00);
    pulse(3);
    rd(8'hD0, v); check("R5 resume", v, 8'h03);

    // R4 full chain
    wr(8'hB0, 8'h10); wr(8'hB0, 8'h00);
    pulse(320);
    rd(8'hD2, v); check("R4 min wrap", v, 8'h00);
    rd(8'hD3, v); check("R4 mid carry", v, 8'h01);
    pulse(3520);
    rd(8'hD3, v); check("R4 mid wrap", v, 8'h00);
    rd(8'hD4, v); check("R4 top", v, 8'h03);
    pulse(1280);
    rd(8'hD4, v); check("R4 top wrap", v, 8'h00);
    rd(8'hD0, v); check("R4 base", v, 8'h00);

    // R9 unmapped reads
    rd(8'h42, v); check("R9 unmapped", v, 8'hFF);
    rd(8'hB0, v); check("R9 ctrl", v, 8'hFF);
    rd(8'hD5, v); check("R9 past top", v, 8'hFF);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule